// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block times the control strobes that surround one analog-to-digital conversion of a sampled video level. A rising edge on the source start input begins a fixed timeline. After a set delay, the block raises a track/hold control. A little later it raises a converter start strobe. Each strobe stays high for a set number of counts and then drops.

Once the start strobe is up, the block waits for the converter's active-low completion flag. A fixed number of counts after that flag is seen, it pulls its own active-low done output low. Done stays low until the next accepted start.

The block is meant for a 1 MHz timing clock, so every count is one microsecond. All delays and widths are parameters, and the block counts them on that clock. The analog hold circuit and the converter lie outside the block. Every input is taken to be synchronous to the timing clock.

Top module: `adc_conv_seq`

## Requirements
- R1: A synchronous active-high reset drives hold and conv_start low and done_n high, and abandons any running sequence. After reset, and before any start edge is accepted, a low level on cmplt_n leaves done_n high.
- R2: A start is accepted at the first clock edge E0 that samples src_start high after it was sampled low. hold is first high after edge E0+HOLD_DLY (default 15).
- R3: hold stays high for exactly HOLD_W counts (default 18), falling after edge E0+33. hold is high whenever conv_start rises.
- R4: conv_start is first high after edge E0+START_DLY (default 19). It stays high for exactly START_W counts (default 31), falling after edge E0+50.
- R5: Only clock edges from E0+START_DLY+1 onward are examined for completion. done_n falls DONE_DLY counts (default 2) after the first such edge that samples cmplt_n low. A cmplt_n that is already low before that window is taken at edge E0+20.
- R6: Start edges are ignored until two conditions both hold: done_n is low, and both strobes have ended (edge E0+50). A src_start held high across that point does not start a new sequence.
- R7: done_n is high at power-up and after reset. Once low, it stays low until the clock edge that accepts the next start, where it returns high.
- R8: A completion that arrives after conv_start has already fallen still finishes the handshake with the same DONE_DLY delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock, one count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| src_start | input | 1 | Start request from the sweep source; its rising edge launches a sequence |
| cmplt_n | input | 1 | Active-low conversion-complete flag from the converter |
| hold | output | 1 | Track/hold control, registered |
| conv_start | output | 1 | Converter start strobe, registered |
| done_n | output | 1 | Active-low sequence-done flag, registered |

## Verification
The assertions assume that src_start and cmplt_n change only between clock edges. They also assume the converter keeps cmplt_n low until done_n has fallen, or releases it only after that. The bench drives both inputs on the falling clock edge. It holds cmplt_n low from the chosen completion cycle until the sequence has been observed, and only then releases it. Completion is placed early, nominal, short and late relative to the start strobe, and extra start edges are placed inside the busy window, so each requirement is reached without breaking those assumptions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/seq_timeline.sv
module seq_timeline #(
  parameter int unsigned LAST = 50,
  parameter int unsigned W    = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  output logic [W-1:0] tm,
  output logic [W-1:0] tm_nx
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  always_comb begin
    if (load)              tm_nx = '0;
    else if (tm == LAST_V) tm_nx = LAST_V;
    else                   tm_nx = tm + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tm <= LAST_V;
    else     tm <= tm_nx;
  end

  // R2: the count advances by one each cycle until it saturates
  a_r2_steady_count: assert property (@(posedge clk) disable iff (rst)
    (!load && tm != LAST_V) |=> (tm == $past(tm) + 1'b1));
endmodule

// File: rtl/seq_window.sv
module seq_window #(
  parameter int unsigned W     = 6,
  parameter int unsigned BEGIN = 15,
  parameter int unsigned WIDTH = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tm_nx,
  output logic         pulse
);
  localparam int unsigned STOP = BEGIN + WIDTH;

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= (32'(tm_nx) >= BEGIN) && (32'(tm_nx) < STOP);
  end
endmodule

// File: rtl/seq_done.sv
module seq_done #(
  parameter int unsigned W      = 6,
  parameter int unsigned ARM_AT = 19,
  parameter int unsigned DD     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] tm,
  input  logic         cmplt_n,
  output logic         done_n
);
  localparam int unsigned DW = (DD > 1) ? $clog2(DD) : 1;
  localparam logic [DW-1:0] DCNT_END = DW'(DD - 1);

  logic          seen;
  logic [DW-1:0] dcnt;
  logic          armed;

  assign armed = run && (32'(tm) >= ARM_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen   <= 1'b0;
      dcnt   <= '0;
      done_n <= 1'b1;
    end else if (load) begin
      seen   <= 1'b0;
      dcnt   <= '0;
      done_n <= 1'b1;
    end else if (!seen && done_n && armed && !cmplt_n) begin
      seen <= 1'b1;
      dcnt <= '0;
    end else if (seen && done_n) begin
      if (dcnt == DCNT_END) done_n <= 1'b0;
      else                  dcnt   <= dcnt + 1'b1;
    end
  end

  // R5: done only falls once a completion has been captured
  a_r5_done_needs_cmplt: assert property (@(posedge clk) disable iff (rst)
    $fell(done_n) |-> $past(seen));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned HOLD_DLY  = 15,
  parameter int unsigned HOLD_W    = 18,
  parameter int unsigned START_DLY = 19,
  parameter int unsigned START_W   = 31,
  parameter int unsigned DONE_DLY  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src_start,
  input  logic cmplt_n,
  output logic hold,
  output logic conv_start,
  output logic done_n
);
  localparam int unsigned LAST = max2(HOLD_DLY + HOLD_W, START_DLY + START_W);
  localparam int unsigned CW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] LAST_V = CW'(LAST);

  seq_state_e    st;
  logic          src_q;
  logic          rise;
  logic          ready;
  logic          load;
  logic [CW-1:0] tm;
  logic [CW-1:0] tm_nx;

  assign rise  = src_start && !src_q;
  assign ready = (st == SEQ_IDLE) || (!done_n && tm == LAST_V);
  assign load  = rise && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      st    <= SEQ_IDLE;
    end else begin
      src_q <= src_start;
      if (load) st <= SEQ_RUN;
    end
  end

  seq_timeline #(.LAST(LAST), .W(CW)) u_tl (
    .clk(clk), .rst(rst), .load(load), .tm(tm), .tm_nx(tm_nx)
  );

  seq_window #(.W(CW), .BEGIN(HOLD_DLY), .WIDTH(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .tm_nx(tm_nx), .pulse(hold)
  );

  seq_window #(.W(CW), .BEGIN(START_DLY), .WIDTH(START_W)) u_start (
    .clk(clk), .rst(rst), .tm_nx(tm_nx), .pulse(conv_start)
  );

  seq_done #(.W(CW), .ARM_AT(START_DLY), .DD(DONE_DLY)) u_done (
    .clk(clk), .rst(rst), .load(load), .run(st == SEQ_RUN), .tm(tm),
    .cmplt_n(cmplt_n), .done_n(done_n)
  );

  // R1: reset leaves every output idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!hold && !conv_start && done_n));

  // R3: the hold control is already up when the start strobe rises
  a_r3_hold_covers_start: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start) |-> hold);

  // R5: done cannot fall before the start strobe plus the done delay
  a_r5_done_not_early: assert property (@(posedge clk) disable iff (rst)
    $fell(done_n) |-> (32'(tm) >= START_DLY + 1 + DONE_DLY));

  // R6: the timeline is never restarted while busy
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_RUN && !(!done_n && tm == LAST_V)) |=> (tm != '0));

  // R7: done only returns high on an accepted start
  a_r7_done_release: assert property (@(posedge clk) disable iff (rst)
    $rose(done_n) |-> (tm == '0));
endmodule

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_start = 1'b0;
  logic cmplt_n = 1'b1;
  logic hold, conv_start, done_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_conv_seq dut (
    .clk(clk), .rst(rst), .src_start(src_start), .cmplt_n(cmplt_n),
    .hold(hold), .conv_start(conv_start), .done_n(done_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One sequence, sampled at the falling edge after each rising edge E0+i.
  task automatic run_seq(input string tag, input int cmplt_idx, input int retrig_idx,
                         input int drop_idx, input int exp_done);
    int hr = -1, hf = -1, ar = -1, af = -1, df = -1, extra = 0;
    logic ph = 1'b0, pa = 1'b0, pd = 1'b1;
    @(negedge clk); src_start = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (i == 0) check("R7", {tag, " done_n high on accept"}, done_n, 1);
      if (hold && !ph) begin if (hr < 0) hr = i; else extra++; end
      if (!hold && ph && hf < 0) hf = i;
      if (conv_start && !pa) begin if (ar < 0) ar = i; else extra++; end
      if (!conv_start && pa && af < 0) af = i;
      if (!done_n && pd && df < 0) df = i;
      ph = hold; pa = conv_start; pd = done_n;
      if (i == cmplt_idx) cmplt_n = 1'b0;
      if (i == 1) src_start = 1'b0;
      if (i == retrig_idx) src_start = 1'b1;
      if (i == drop_idx) src_start = 1'b0;
    end
    check("R2", {tag, " hold rise"}, hr, 15);
    check("R3", {tag, " hold fall"}, hf, 33);
    check("R4", {tag, " start rise"}, ar, 19);
    check("R4", {tag, " start fall"}, af, 50);
    check("R5", {tag, " done fall"}, df, exp_done);
    check("R6", {tag, " no extra strobes"}, extra, 0);
    check("R7", {tag, " done_n held low"}, done_n, 0);
    cmplt_n = 1'b1; src_start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "hold after reset", hold, 0);
    check("R1", "conv_start after reset", conv_start, 0);
    check("R1", "done_n after reset", done_n, 1);
    cmplt_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R1", "cmplt without start ignored", done_n, 1);
    cmplt_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_nominal();   // R2 R3 R4 R5, R6 retrigger at E0+40
    run_seq("nominal", 30, 40, 42, 33);
  endtask

  task automatic t_short();     // R5 completion 5 counts after start strobe
    run_seq("short", 23, -1, -1, 26);
  endtask

  task automatic t_early();     // R5 completion already low before window
    run_seq("early", 3, -1, -1, 22);
  endtask

  task automatic t_late();      // R8 completion after strobe fell; R6 level held
    run_seq("late", 58, 40, 70, 61);
  endtask

  task automatic t_mid_reset(); // R1 reset in the middle of a sequence
    @(negedge clk); src_start = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      if (i == 1) src_start = 1'b0;
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "mid reset hold", hold, 0);
    check("R1", "mid reset conv_start", conv_start, 0);
    check("R1", "mid reset done_n", done_n, 1);
    repeat (60) @(negedge clk);
    check("R1", "no strobe after mid reset", hold | conv_start, 0);
  endtask

  initial begin
    t_reset_state();
    t_nominal();
    t_short();
    t_early();
    t_late();
    t_mid_reset();
    t_nominal();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule